// File: doc/BRIEF.md
# Channel Enable Register with Set/Clear/Toggle Aliases

This block holds one enable bit per PWM channel in a small memory-mapped register. Besides its plain address, the register answers at three more word addresses that change only the bits written as one: one address ORs the written bits in, one removes them, and one inverts them. Software can therefore start or stop a single channel with one store and never needs a read-modify-write sequence that could race with another agent changing a neighbouring bit.

The bus side is a simple synchronous port: a byte address, a write strobe with write data, and a read strobe whose data appears one cycle later. The channel side is a vector of enable lines, one per channel, driven straight from the register flops. The number of channels is a parameter, eight by default.

Top module: `pwm_chan_ctrl`

## Requirements
- R1: After reset every register bit is zero, so every `ch_en` line is low and `rdata` reads zero.
- R2: A write to the plain address (word 0, byte offset 0x0) replaces the register with `wdata[NUM_CH-1:0]`.
- R3: A write to the set alias (byte offset 0x4) makes each register bit n one where `wdata[n]` is one and leaves the other bits unchanged.
- R4: A write to the clear alias (byte offset 0x8) makes each register bit n zero where `wdata[n]` is one and leaves the other bits unchanged.
- R5: A write to the toggle alias (byte offset 0xC) inverts each register bit n where `wdata[n]` is one and leaves the other bits unchanged.
- R6: A write of all zeros to the set, clear or toggle alias leaves the register unchanged, and `wdata` bits at or above `NUM_CH` have no effect through any alias.
- R7: A read strobe at any of the four offsets 0x0, 0x4, 0x8 or 0xC returns, in the next cycle, the register value zero-extended to 32 bits; a read and a write in the same cycle return the value before the write.
- R8: A write changes the register on the clock edge that samples the strobe, and `ch_en` shows the new value from that edge on (the cycle after the strobe).
- R9: Address bits 1:0 are ignored; an access whose address bits above bit 3 are not all zero changes nothing, and a read there returns zero.
- R10: With no write strobe the register, and so `ch_en`, keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data, valid the cycle after `rd_en`, held until the next read |
| ch_en | output | NUM_CH | Per-channel enable, bit n enables channel n |

## Verification
On every cycle the checker relates each alias write to the enable vector one cycle later (replace, OR, AND-NOT, XOR of the previous value), holds the vector stable when no valid write occurs, and compares each read result with the enable value of the read cycle or with zero off the decoded range. What the checker cannot show is that long mixed sequences of aliases reach the intended state from arbitrary histories, that stray upper data bits never leak in, and that sub-word address bits are truly ignored; the bench covers these with seeded random operations against its own model plus directed cases for zero writes, all-ones toggles and out-of-range addresses.

// File: rtl/chanctl_pkg.sv
package chanctl_pkg;

  localparam int BUS_W = 32;

  // Alias selected by byte address bits 3:2; the order is the decode itself.
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TGL   = 2'd3
  } alias_op_e;

  // Next value of one register bit for an alias write.
  function automatic logic next_bit(alias_op_e op, logic cur, logic wbit);
    logic res;
    unique case (op)
      OP_WRITE: res = wbit;
      OP_SET:   res = cur | wbit;
      OP_CLR:   res = cur & ~wbit;
      OP_TGL:   res = cur ^ wbit;
      default:  res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/chanctl_decode.sv
module chanctl_decode #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wr_en,
  input  logic                  rd_en,
  output logic                  in_range,
  output logic                  wr_hit,
  output logic                  rd_hit,
  output chanctl_pkg::alias_op_e op
);
  localparam int HI_W = ADDR_W - 4;

  logic [HI_W-1:0] hi_bits;
  logic [1:0]      unused_sub_word;

  assign hi_bits         = addr[ADDR_W-1:4];
  assign unused_sub_word = addr[1:0];
  assign in_range        = (hi_bits == '0);
  assign wr_hit          = wr_en & in_range;
  assign rd_hit          = rd_en & in_range;
  assign op              = chanctl_pkg::alias_op_e'(addr[3:2]);
endmodule

// File: rtl/chanctl_reg.sv
module chanctl_reg #(
  parameter int NUM_CH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_hit,
  input  chanctl_pkg::alias_op_e op,
  input  logic [NUM_CH-1:0]      wbits,
  output logic [NUM_CH-1:0]      q
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_bit
    logic d;
    assign d = chanctl_pkg::next_bit(op, q[n], wbits[n]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[n] <= 1'b0;
      else if (wr_hit) q[n] <= d;
    end
  end
endmodule

// File: rtl/chanctl_rdport.sv
module chanctl_rdport #(
  parameter int NUM_CH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  logic                          rd_hit,
  input  logic [NUM_CH-1:0]             q,
  output logic [chanctl_pkg::BUS_W-1:0] rdata
);
  localparam int PAD_W = chanctl_pkg::BUS_W - NUM_CH;

  logic [chanctl_pkg::BUS_W-1:0] word;

  if (PAD_W > 0) begin : g_pad
    assign word = {{PAD_W{1'b0}}, q};
  end else begin : g_nopad
    assign word = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_hit ? word : '0;
  end
endmodule

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  input  logic              rd_en,
  output logic [31:0]       rdata,
  output logic [NUM_CH-1:0] ch_en
);
  // Named internal events, visible to the bound checker.
  logic                   in_range;
  logic                   wr_hit;
  logic                   rd_hit;
  chanctl_pkg::alias_op_e op;
  logic [NUM_CH-1:0]      wbits;
  logic [NUM_CH-1:0]      q;

  assign wbits = wdata[NUM_CH-1:0];

  chanctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .in_range(in_range), .wr_hit(wr_hit), .rd_hit(rd_hit), .op(op)
  );

  chanctl_reg #(.NUM_CH(NUM_CH)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .op(op),
    .wbits(wbits), .q(q)
  );

  chanctl_rdport #(.NUM_CH(NUM_CH)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_hit(rd_hit),
    .q(q), .rdata(rdata)
  );

  assign ch_en = q;
endmodule

// File: rtl/pwm_chan_ctrl_chk.sv
module pwm_chan_ctrl_chk #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [31:0]       wdata,
  input logic              rd_en,
  input logic [31:0]       rdata,
  input logic [NUM_CH-1:0] ch_en,
  input logic              wr_hit
);
  logic          ok_addr;
  logic [1:0]    sel;
  logic [NUM_CH-1:0] wb;
  assign ok_addr = (addr >> 4) == '0;
  assign sel     = addr[3:2];
  assign wb      = wdata[NUM_CH-1:0];

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> ch_en == '0);

  p_plain_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ok_addr && sel == 2'd0) |=> ch_en == $past(wb));

  p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ok_addr && sel == 2'd1) |=> ch_en == ($past(ch_en) | $past(wb)));

  p_clear_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ok_addr && sel == 2'd2) |=> ch_en == ($past(ch_en) & ~$past(wb)));

  p_toggle_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ok_addr && sel == 2'd3) |=> ch_en == ($past(ch_en) ^ $past(wb)));

  p_zero_alias_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel != 2'd0 && wb == '0) |=> $stable(ch_en));

  p_read_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ok_addr) |=> rdata == 32'($past(ch_en)));

  p_out_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !ok_addr) |=> rdata == 32'd0);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ch_en));

  p_hit_decode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |-> (wr_en && ok_addr));
endmodule

bind pwm_chan_ctrl pwm_chan_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rd_en(rd_en), .rdata(rdata), .ch_en(ch_en), .wr_hit(wr_hit)
);

// File: tb/tb_pwm_chan_ctrl.sv
module tb_pwm_chan_ctrl;
  localparam int NUM_CH = 8;
  localparam int ADDR_W = 8;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] addr;
  logic              wr_en;
  logic [31:0]       wdata;
  logic              rd_en;
  logic [31:0]       rdata;
  logic [NUM_CH-1:0] ch_en;

  int checks = 0;
  int errors = 0;
  logic [NUM_CH-1:0] model = '0;

  pwm_chan_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .ch_en(ch_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench restatement of the alias effect, written over whole words.
  function automatic logic [NUM_CH-1:0] expect_after(logic [NUM_CH-1:0] cur,
      logic [ADDR_W-1:0] a, logic [31:0] d);
    logic [NUM_CH-1:0] m;
    m = d[NUM_CH-1:0];
    if (a >= 8'h10) return cur;
    case (a[3:2])
      2'd0: return m;
      2'd1: return cur | m;
      2'd2: return cur & ~m;
      default: return cur ^ m;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at falling edge, check at next falling edge (after one rising edge).
  task automatic do_write(logic [ADDR_W-1:0] a, logic [31:0] d, string req);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model = expect_after(model, a, d);
    check(req, 32'(ch_en), 32'(model));
  endtask

  task automatic do_read(logic [ADDR_W-1:0] a, string req);
    logic [31:0] exp;
    exp = (a >= 8'h10) ? 32'd0 : 32'(model);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; wdata = '0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset ch_en", 32'(ch_en), 32'd0);
    check("R1 reset rdata", rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    do_write(8'h00, 32'hFFFF_FF5A, "R2 plain write, R6 upper bits");
    do_write(8'h04, 32'h0000_0001, "R3 set one-hot");
    do_write(8'h08, 32'h0000_0002, "R4 clear one-hot");
    do_write(8'h0C, 32'h0000_00FF, "R5 toggle all");
    do_write(8'h04, 32'h0000_0000, "R6 zero set");
    do_write(8'h08, 32'hFFFF_FF00, "R6 zero clear, upper bits only");
    do_write(8'h0C, 32'h0000_0000, "R6 zero toggle");
    do_write(8'h07, 32'h0000_0080, "R9 sub-word bits ignored");
    do_write(8'h14, 32'h0000_00FF, "R9 out of range write");
    do_write(8'h40, 32'h0000_0000, "R9 out of range plain");
    for (int i = 0; i < 4; i++) do_read(8'(4 * i), "R7 read any alias");
    do_read(8'h20, "R9 out of range read");

    // Read and write in the same cycle: old value returned, R7/R8.
    begin
      logic [31:0] old;
      old = 32'(model);
      addr = 8'h0C; wdata = 32'h0000_000F; wr_en = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      model = expect_after(model, 8'h0C, 32'h0000_000F);
      check("R7 read sees pre-write value", rdata, old);
      check("R8 write visible next cycle", 32'(ch_en), 32'(model));
    end

    // Idle cycles hold the value, R10.
    repeat (3) @(negedge clk);
    check("R10 hold when idle", 32'(ch_en), 32'(model));

    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      logic [31:0] d;
      a = ($urandom % 8 == 0) ? 8'($urandom) : 8'(($urandom % 4) * 4 + $urandom % 4);
      d = $urandom;
      if ($urandom % 3 == 0) d = 32'(1) << ($urandom % NUM_CH);
      if ($urandom % 4 == 0) do_read(a, "R7 random read");
      else do_write(a, d, "R2-R5 random alias write");
    end

    rst_n = 1'b0;
    @(negedge clk);
    model = '0;
    check("R1 reset again", 32'(ch_en), 32'd0);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule